// File: doc/BRIEF.md
# Serial DAC Input Interface

This block is the digital front end of a single-channel voltage-output converter. A host writes it over a three-wire serial link: an active-low frame select (`sync_n`), a serial clock (`sclk`) and a data line (`din`). The three pins are asynchronous to the block's system clock `clk`, so they first pass through a synchronizer. Each falling `sclk` edge inside a frame then shifts one bit in, most significant bit first.

A frame has 24 bits. The top 6 bits are padding. The next 2 bits select the operating mode, and the low 16 bits carry the converter code. The code register and the mode register change only when the 24th falling edge arrives. A frame cut short by `sync_n` rising changes nothing. The mode is also decoded into four mutually exclusive controls for the analog output stage: normal drive, a 1 kΩ pull to ground, a 100 kΩ pull to ground, or open. A one-cycle strobe marks every committed frame.

Each `sclk` level must be held for at least two `clk` cycles so that the synchronizer can see it. `SYNC_STAGES` sets the depth of the synchronizer. `RESET_MIDSCALE` selects whether the code comes up at zero or at midscale.

Top module: `dac_serial_front`

## Requirements
- R1: After reset the mode is normal (`pd_mode` = 00, `drv_on` = 1). `dac_code` is 0, or 1 followed by zeros (0x8000 at 16 bits) when `RESET_MIDSCALE` = 1. No update strobe has been issued.
- R2: A frame starts when `sync_n` falls after having been high. One `din` bit is taken on each falling `sclk` edge, MSB first. Frame bit 23 is sent first, and frame bits 15:0 become `dac_code`.
- R3: Frame bits 23:18 are ignored: their values never reach any output.
- R4: Frame bits 17:16 set `pd_mode`: 00 normal drive, 01 1 kΩ to ground, 10 100 kΩ to ground, 11 open. Exactly one of `drv_on`, `pull_1k`, `pull_100k`, `out_open` is high at all times.
- R5: `dac_code` and `pd_mode` change only on the 24th falling `sclk` edge of a frame. After 23 edges with `sync_n` still low, the outputs are unchanged.
- R6: If `sync_n` rises before the 24th edge, the partial frame is discarded and the shift state is cleared. The next frame is assembled only from its own bits.
- R7: After the 24th edge, further falling `sclk` edges while `sync_n` stays low are ignored.
- R8: After a committed frame, `sync_n` must go high and then fall again before the next frame can be committed.
- R9: Entering a power-down mode does not clear the code. `dac_code` holds the code carried by the frame that selected the power-down mode.
- R10: `upd_stb` is high for exactly one `clk` cycle per committed frame, in the same cycle in which the new code and mode appear.
- R11: If `sync_n` rises in the same synchronized cycle as the 24th falling edge, the frame is aborted and nothing changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_n | input | 1 | Frame select, active low, asynchronous |
| sclk | input | 1 | Serial clock; bits are taken on its falling edge |
| din | input | 1 | Serial data, MSB first |
| dac_code | output | CODE_W (16) | Stored converter code |
| pd_mode | output | 2 | Operating mode: 00 run, 01 1 kΩ, 10 100 kΩ, 11 open |
| drv_on | output | 1 | Output amplifier drives the pin |
| pull_1k | output | 1 | Output tied to ground through 1 kΩ |
| pull_100k | output | 1 | Output tied to ground through 100 kΩ |
| out_open | output | 1 | Output left high-impedance |
| upd_stb | output | 1 | One-cycle pulse when a frame commits |

## Verification
The bench builds the block with `RESET_MIDSCALE` = 1 and the default 16-bit code and two-stage synchronizer. This setting makes the midscale power-on value observable, so the reset check can tell it apart from an all-zero register. Holding each `sclk` phase for four clocks keeps every edge visible through the synchronizer. It also lets the bench line up the 24th falling edge with the rise of `sync_n` exactly, which reaches the abort-wins corner case. Padding bits with mixed values, all four mode codes and codes at zero, full scale and alternating patterns cover the field positions.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'b00,
    MODE_PD_1K   = 2'b01,
    MODE_PD_100K = 2'b10,
    MODE_PD_OPEN = 2'b11
  } pd_mode_e;

  typedef struct packed {
    logic drive;
    logic pull_1k;
    logic pull_100k;
    logic open;
  } stage_ctl_t;

  function automatic stage_ctl_t decode_stage(pd_mode_e m);
    stage_ctl_t s;
    s = '0;
    case (m)
      MODE_RUN:     s.drive     = 1'b1;
      MODE_PD_1K:   s.pull_1k   = 1'b1;
      MODE_PD_100K: s.pull_100k = 1'b1;
      default:      s.open      = 1'b1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dac_if_sync.sv
module dac_if_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{RST_VAL}};
    end else begin
      pipe[0] <= async_i;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign sync_o = pipe[STAGES-1];

endmodule

// File: rtl/dac_if_frame.sv
module dac_if_frame #(
  parameter int FRAME_W = 24,
  parameter int PAY_W   = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_n_s,
  input  logic             sclk_s,
  input  logic             din_s,
  output logic             frame_commit,
  output logic             frame_abort,
  output logic [PAY_W-1:0] frame_word
);

  localparam int               CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_W - 1);

  logic             sclk_q;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [PAY_W-1:0] shreg;
  logic             sclk_fall;
  logic             in_frame;

  assign sclk_fall    = sclk_q & ~sclk_s;
  assign in_frame     = armed & ~sync_n_s;
  assign frame_word   = {shreg[PAY_W-2:0], din_s};
  assign frame_commit = in_frame & sclk_fall & (cnt == LAST);
  assign frame_abort  = sync_n_s & (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      armed  <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (sync_n_s) begin
        armed <= 1'b1;
        cnt   <= '0;
        shreg <= '0;
      end else if (in_frame && sclk_fall) begin
        shreg <= frame_word;
        if (cnt == LAST) begin
          cnt   <= '0;
          armed <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dac_if_regs.sv
module dac_if_regs
  import dac_if_pkg::*;
#(
  parameter int CODE_W         = 16,
  parameter bit RESET_MIDSCALE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [CODE_W+1:0] payload,
  output logic [CODE_W-1:0] code_q,
  output pd_mode_e          mode_q,
  output logic              upd_stb,
  output stage_ctl_t        stage
);

  localparam logic [CODE_W-1:0] RST_CODE =
    RESET_MIDSCALE ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

  function automatic logic [CODE_W-1:0] code_of(logic [CODE_W+1:0] p);
    return p[CODE_W-1:0];
  endfunction

  function automatic pd_mode_e mode_of(logic [CODE_W+1:0] p);
    return pd_mode_e'(p[CODE_W +: 2]);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= RST_CODE;
      mode_q  <= MODE_RUN;
      upd_stb <= 1'b0;
    end else begin
      upd_stb <= commit;
      if (commit) begin
        code_q <= code_of(payload);
        mode_q <= mode_of(payload);
      end
    end
  end

  assign stage = decode_stage(mode_q);

endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dac_if_pkg::*;
#(
  parameter int CODE_W         = 16,
  parameter int PAD_W          = 6,
  parameter int SYNC_STAGES    = 2,
  parameter bit RESET_MIDSCALE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              din,
  output logic [CODE_W-1:0] dac_code,
  output logic [1:0]        pd_mode,
  output logic              drv_on,
  output logic              pull_1k,
  output logic              pull_100k,
  output logic              out_open,
  output logic              upd_stb
);

  localparam int PAY_W   = CODE_W + 2;
  localparam int FRAME_W = PAD_W + PAY_W;

  logic [2:0]       pins_s;
  logic             frame_commit;
  logic             frame_abort;
  logic [PAY_W-1:0] frame_word;
  pd_mode_e         mode_q;
  stage_ctl_t       stage;

  dac_if_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({sync_n, sclk, din}),
    .sync_o (pins_s)
  );

  dac_if_frame #(
    .FRAME_W(FRAME_W),
    .PAY_W  (PAY_W)
  ) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_n_s    (pins_s[2]),
    .sclk_s      (pins_s[1]),
    .din_s       (pins_s[0]),
    .frame_commit(frame_commit),
    .frame_abort (frame_abort),
    .frame_word  (frame_word)
  );

  dac_if_regs #(
    .CODE_W        (CODE_W),
    .RESET_MIDSCALE(RESET_MIDSCALE)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (frame_commit),
    .payload(frame_word),
    .code_q (dac_code),
    .mode_q (mode_q),
    .upd_stb(upd_stb),
    .stage  (stage)
  );

  assign pd_mode   = mode_q;
  assign drv_on    = stage.drive;
  assign pull_1k   = stage.pull_1k;
  assign pull_100k = stage.pull_100k;
  assign out_open  = stage.open;

endmodule

// File: rtl/dac_serial_front_chk.sv
module dac_serial_front_chk #(
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_commit,
  input logic              frame_abort,
  input logic              upd_stb,
  input logic [CODE_W-1:0] dac_code,
  input logic [1:0]        pd_mode,
  input logic              drv_on,
  input logic              pull_1k,
  input logic              pull_100k,
  input logic              out_open
);

  assert_stage_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({drv_on, pull_1k, pull_100k, out_open}));

  assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> upd_stb);

  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_mode) |-> upd_stb);

  assert_commit_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_commit |=> upd_stb);

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);

  assert_abort_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> !upd_stb);

endmodule

bind dac_serial_front dac_serial_front_chk #(.CODE_W(CODE_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_commit(frame_commit),
  .frame_abort (frame_abort),
  .upd_stb     (upd_stb),
  .dac_code    (dac_code),
  .pd_mode     (pd_mode),
  .drv_on      (drv_on),
  .pull_1k     (pull_1k),
  .pull_100k   (pull_100k),
  .out_open    (out_open)
);

// File: tb/dac_serial_front_tb_top.sv
`timescale 1ns/1ps
module dac_serial_front_tb_top;

  localparam int HOLD = 4;
  localparam int NVEC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_n = 1'b1;
  logic        sclk = 1'b1;
  logic        din = 1'b0;
  logic [15:0] dac_code;
  logic [1:0]  pd_mode;
  logic        drv_on, pull_1k, pull_100k, out_open, upd_stb;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dac_serial_front #(.RESET_MIDSCALE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .din(din),
    .dac_code(dac_code), .pd_mode(pd_mode), .drv_on(drv_on),
    .pull_1k(pull_1k), .pull_100k(pull_100k), .out_open(out_open),
    .upd_stb(upd_stb)
  );

  always @(posedge clk) if (rst_n && upd_stb) stb_cnt++;

  // {frame, expected code, expected mode, expected {drive,1k,100k,open}}
  localparam logic [45:0] VEC [NVEC] = '{
    {24'hFC1234, 16'h1234, 2'b00, 4'b1000},
    {24'h01FFFF, 16'hFFFF, 2'b01, 4'b0100},
    {24'hAA0000, 16'h0000, 2'b10, 4'b0010},
    {24'h575A5A, 16'h5A5A, 2'b11, 4'b0001},
    {24'h008001, 16'h8001, 2'b00, 4'b1000},
    {24'h02C3C3, 16'hC3C3, 2'b10, 4'b0010}
  };

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] w, input int nbits, input bit release_sync);
    sync_n = 1'b0;
    hold(HOLD);
    for (int i = 0; i < nbits; i++) begin
      din  = w[23-i];
      sclk = 1'b1;
      hold(HOLD);
      sclk = 1'b0;
      hold(HOLD);
    end
    sclk = 1'b1;
    hold(HOLD);
    if (release_sync) begin
      sync_n = 1'b1;
      hold(2 * HOLD);
    end
  endtask

  function automatic logic [3:0] stage_now();
    return {drv_on, pull_1k, pull_100k, out_open};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    hold(3);
    rst_n = 1'b1;
    hold(4);

    // R1 reset state (midscale build)
    check("R1 code", dac_code, 16'h8000);
    check("R1 mode", pd_mode, 2'b00);
    check("R1 stage", stage_now(), 4'b1000);
    check("R1 strobe", stb_cnt, 0);

    // R2 R3 R4 R10: vector table
    for (int v = 0; v < NVEC; v++) begin
      base = stb_cnt;
      send(VEC[v][45:22], 24, 1'b1);
      check("R2 R3 code", dac_code, VEC[v][21:6]);
      check("R4 mode", pd_mode, VEC[v][5:4]);
      check("R4 stage", stage_now(), VEC[v][3:0]);
      check("R10 one strobe", stb_cnt - base, 1);
    end

    // R5: 23 edges then hold low, no change; then abort
    send(24'h00ABCD, 23, 1'b0);
    check("R5 code after 23 edges", dac_code, 16'hC3C3);
    check("R5 mode after 23 edges", pd_mode, 2'b10);
    sync_n = 1'b1;
    hold(2 * HOLD);
    check("R5 code after abort", dac_code, 16'hC3C3);

    // R6: aborted partial of ones, then a clean frame
    send(24'hFFFFFF, 10, 1'b1);
    check("R6 partial ignored", dac_code, 16'hC3C3);
    send(24'h000F0F, 24, 1'b1);
    check("R6 clean code", dac_code, 16'h0F0F);
    check("R6 clean mode", pd_mode, 2'b00);

    // R7 R8: extra edges with sync still low are ignored
    base = stb_cnt;
    send(24'h001111, 24, 1'b0);
    send(24'h032222, 24, 1'b0);
    check("R7 code", dac_code, 16'h1111);
    check("R7 mode", pd_mode, 2'b00);
    check("R8 strobe count", stb_cnt - base, 1);
    sync_n = 1'b1;
    hold(2 * HOLD);
    send(24'h003333, 24, 1'b1);
    check("R8 next frame", dac_code, 16'h3333);

    // R9: power-down keeps the code
    send(24'h014444, 24, 1'b1);
    check("R9 code in power-down", dac_code, 16'h4444);
    check("R9 stage", stage_now(), 4'b0100);
    hold(20);
    check("R9 code held", dac_code, 16'h4444);

    // R11: sync rise together with the 24th falling edge
    base = stb_cnt;
    sync_n = 1'b0;
    hold(HOLD);
    for (int i = 0; i < 24; i++) begin
      din  = 1'b1;
      sclk = 1'b1;
      hold(HOLD);
      sclk = 1'b0;
      if (i == 23) sync_n = 1'b1;
      hold(HOLD);
    end
    sclk = 1'b1;
    hold(2 * HOLD);
    check("R11 code", dac_code, 16'h4444);
    check("R11 mode", pd_mode, 2'b01);
    check("R11 strobe", stb_cnt - base, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule